// File: doc/BRIEF.md
# Multiplexed DRAM access sequencer

This block is a synchronous controller placed between a simple host port and a 64K x 1 dynamic memory that takes its address in two halves over eight shared pins. The host presents a 16-bit address, a write flag and one data bit, and holds `req` high until a one-cycle `ready` pulse. The sequencer splits the address into a row byte (upper half) and a column byte (lower half). It drives the active-low row and column strobes and the write strobe with every interval counted in whole clock cycles. It returns the read bit alongside `ready`.

Writes are always issued in early-write order, so the memory's output stays off for the whole write. If the next request arrives while the row is still open, names the same row byte, and there is enough time left before the row-strobe low limit, the sequencer keeps the row strobe low and cycles only the column strobe. Any other request closes the row, waits out the precharge and opens a new one. After reset the block holds all strobes idle for a power-up pause and then runs a fixed number of row-only dummy cycles. It serves no request until both have finished. Refresh belongs to a separate block.

Top module: `dramSeq`

## Requirements
- R1: While reset is asserted, and for T_INIT cycles after its release, the row, column and write strobes stay high and `ready` stays low.
- R2: After the pause, exactly INIT_CYC row-strobe cycles with the column strobe held high occur before the first column strobe. A request held during this time waits until they are done.
- R3: The row byte `reqAddr[15:8]` is on `memAddr` when the row strobe falls and stays there for at least T_RAH cycles. The column byte `reqAddr[7:0]` is on `memAddr` when the column strobe falls.
- R4: The column strobe falls no sooner than T_RCD cycles after the row strobe falls.
- R5: Each row-strobe low phase lasts at least T_RASMIN cycles. Each high phase lasts at least T_RP cycles. Successive row-strobe falls are at least T_RC cycles apart.
- R6: The column strobe stays low for at least T_CAS cycles, and `memAddr` does not change while it is low.
- R7: For a read, `rdData` during the `ready` cycle equals the bit the memory presents on `memDout` in the last cycle of the column-strobe low phase.
- R8: For a write, `memWeN` is already low at the column-strobe falling edge and stays unchanged while the column strobe is low. `memDin` then carries the request's data bit, so the bit is stored.
- R9: Each accepted request produces exactly one `ready` pulse, one cycle wide, in the cycle in which the column strobe returns high.
- R10: Same-row requests that follow one another without a gap share one row-strobe low phase. Between their column strobes the column strobe is high for at least T_CP cycles, and successive column-strobe falls are at least T_PC cycles apart.
- R11: A request with a different row byte closes the open row, so every access in an alternating-row sequence gets its own row-strobe fall.
- R12: The row strobe is never low for more than T_RASMAX consecutive cycles. A same-row burst that would exceed this is split across several row-strobe phases.
- R13: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its cycles |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid, held until `ready` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Bits 15:8 are the row, bits 7:0 are the column |
| reqData | input | 1 | Data bit for a write |
| ready | output | 1 | One-cycle completion pulse |
| rdData | output | 1 | Read bit, valid with `ready` |
| memAddr | output | 8 | Multiplexed row/column address to the memory |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write strobe, active low |
| memDin | output | 1 | Data to the memory |
| memDout | input | 1 | Data from the memory |

## Verification
The sequencer is driven against a behavioural memory model that captures the row and column bytes at the strobe edges. The model presents a wrong bit until the column strobe has been low for the full access time, so a capture that comes too early shows up as a data error. It is driven with:
- a request held through initialisation, which tests the pause and the dummy-cycle count;
- back-to-back same-row runs, which tell a page hit from a reopened row;
- alternating rows, which must each get their own row cycle;
- a long same-row run that must be split at the row-strobe low limit.

Pairs of addresses with their bytes swapped, and a write followed by a read of the same bit, expose byte-order and write-ordering faults.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // latch host request
    logic capture;  // sample memory data-out
    logic selCol;   // drive column byte on the address pins
    logic rasOn;    // row strobe asserted
    logic casOn;    // column strobe asserted
    logic weWin;    // window in which a write may assert WE
  } seqStrobe_t;

  typedef enum logic [2:0] {
    S_WAIT, S_IRAS, S_IPRE, S_IDLE, S_ROW, S_COL, S_GAP, S_PRE
  } seqState_t;

endpackage

// File: rtl/dramSeqCtrl.sv
module dramSeqCtrl
  import dram_seq_pkg::*;
#(
  parameter int T_INIT   = 10000,
  parameter int INIT_CYC = 8,
  parameter int T_RCD    = 3,
  parameter int T_RAH    = 2,
  parameter int T_CAS    = 8,
  parameter int T_RASMIN = 15,
  parameter int T_RASMAX = 1000,
  parameter int T_RP     = 10,
  parameter int T_RC     = 27,
  parameter int T_CP     = 6,
  parameter int T_PC     = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic       sameRow,
  output seqStrobe_t strobe,
  output logic       ready
);

  // Effective minimums: a row-low phase long enough for the full cycle time,
  // a column-high gap long enough for the page cycle time
  localparam int RAS_MIN_EFF = (T_RASMIN > T_RC - T_RP) ? T_RASMIN : T_RC - T_RP;
  localparam int CP_EFF      = (T_CP > T_PC - T_CAS) ? T_CP : T_PC - T_CAS;
  localparam int PAGE_LIMIT  = T_RASMAX - CP_EFF - T_CAS;
  localparam int CNT_W       = $clog2(T_INIT + T_RASMAX + 2);
  localparam int INIT_W      = $clog2(INIT_CYC + 1);

  localparam logic [CNT_W-1:0]  C_INIT  = CNT_W'(T_INIT - 1);
  localparam logic [CNT_W-1:0]  C_RASLO = CNT_W'(RAS_MIN_EFF - 1);
  localparam logic [CNT_W-1:0]  C_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0]  C_RCD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0]  C_RAH   = CNT_W'(T_RAH);
  localparam logic [CNT_W-1:0]  C_CAS   = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0]  C_CP    = CNT_W'(CP_EFF - 1);
  localparam logic [CNT_W-1:0]  C_LIMIT = CNT_W'(PAGE_LIMIT);
  localparam logic [INIT_W-1:0] C_ICYC  = INIT_W'(INIT_CYC - 1);

  seqState_t         state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  rasCnt;
  logic [INIT_W-1:0] initCnt;
  logic              pageHit, mustClose;

  assign pageHit   = req && sameRow && (rasCnt < C_LIMIT);
  assign mustClose = (req && !sameRow) || (rasCnt >= C_LIMIT);

  always_comb begin
    nxt = state;
    unique case (state)
      S_WAIT: if (cnt == C_INIT) nxt = S_IRAS;
      S_IRAS: if (cnt == C_RASLO) nxt = S_IPRE;
      S_IPRE: if (cnt == C_RP) nxt = (initCnt == C_ICYC) ? S_IDLE : S_IRAS;
      S_IDLE: if (req) nxt = S_ROW;
      S_ROW:  if (cnt == C_RCD) nxt = S_COL;
      S_COL:  if (cnt == C_CAS) nxt = S_GAP;
      S_GAP: begin
        if (pageHit) begin
          if (cnt >= C_CP) nxt = S_COL;
        end else if (mustClose && (rasCnt >= C_RASLO)) begin
          nxt = S_PRE;
        end
      end
      S_PRE:  if (cnt == C_RP) nxt = S_IDLE;
      default: nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_WAIT;
      cnt     <= '0;
      rasCnt  <= '0;
      initCnt <= '0;
      ready   <= 1'b0;
    end else begin
      state  <= nxt;
      cnt    <= (nxt != state) ? '0 : cnt + 1'b1;
      rasCnt <= (state inside {S_ROW, S_COL, S_GAP}) ? rasCnt + 1'b1 : '0;
      if (state == S_IPRE && nxt != S_IPRE) initCnt <= initCnt + 1'b1;
      ready  <= strobe.capture;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rasOn   = state inside {S_IRAS, S_ROW, S_COL, S_GAP};
    strobe.casOn   = (state == S_COL);
    strobe.selCol  = (state == S_COL) || (state == S_GAP) ||
                     (state == S_ROW && cnt >= C_RAH);
    strobe.weWin   = (state == S_COL) || (state == S_ROW && cnt >= C_RAH);
    strobe.capture = (state == S_COL) && (cnt == C_CAS);
    strobe.load    = (state == S_IDLE && req) || (state == S_GAP && nxt == S_COL);
  end

endmodule

// File: rtl/dramSeqPath.sv
module dramSeqPath
  import dram_seq_pkg::*;
#(
  parameter int ROW_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               reqWrite,
  input  logic [2*ROW_W-1:0] reqAddr,
  input  logic               reqData,
  input  logic               memDout,
  output logic               sameRow,
  output logic               rdData,
  output logic [ROW_W-1:0]   memAddr,
  output logic               memRasN,
  output logic               memCasN,
  output logic               memWeN,
  output logic               memDin
);

  logic [ROW_W-1:0] rowQ, colQ;
  logic             weQ, dataQ, rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ  <= '0;
      colQ  <= '0;
      weQ   <= 1'b0;
      dataQ <= 1'b0;
      rdQ   <= 1'b0;
    end else begin
      if (strobe.load) begin
        rowQ  <= reqAddr[2*ROW_W-1:ROW_W];
        colQ  <= reqAddr[ROW_W-1:0];
        weQ   <= reqWrite;
        dataQ <= reqData;
      end
      if (strobe.capture) rdQ <= memDout;
    end
  end

  assign sameRow = (reqAddr[2*ROW_W-1:ROW_W] == rowQ);
  assign memAddr = strobe.selCol ? colQ : rowQ;
  assign memRasN = ~strobe.rasOn;
  assign memCasN = ~strobe.casOn;
  assign memWeN  = ~(strobe.weWin && weQ);
  assign memDin  = dataQ;
  assign rdData  = rdQ;

endmodule

// File: rtl/dramSeq.sv
module dramSeq
  import dram_seq_pkg::*;
#(
  parameter int ROW_W    = 8,
  parameter int T_INIT   = 10000,
  parameter int INIT_CYC = 8,
  parameter int T_RCD    = 3,
  parameter int T_RAH    = 2,
  parameter int T_CAS    = 8,
  parameter int T_RASMIN = 15,
  parameter int T_RASMAX = 1000,
  parameter int T_RP     = 10,
  parameter int T_RC     = 27,
  parameter int T_CP     = 6,
  parameter int T_PC     = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               req,
  input  logic               reqWrite,
  input  logic [2*ROW_W-1:0] reqAddr,
  input  logic               reqData,
  output logic               ready,
  output logic               rdData,
  output logic [ROW_W-1:0]   memAddr,
  output logic               memRasN,
  output logic               memCasN,
  output logic               memWeN,
  output logic               memDin,
  input  logic               memDout
);

  seqStrobe_t strobe;
  logic       sameRow;

  dramSeqCtrl #(
    .T_INIT(T_INIT), .INIT_CYC(INIT_CYC), .T_RCD(T_RCD), .T_RAH(T_RAH),
    .T_CAS(T_CAS), .T_RASMIN(T_RASMIN), .T_RASMAX(T_RASMAX), .T_RP(T_RP),
    .T_RC(T_RC), .T_CP(T_CP), .T_PC(T_PC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .sameRow(sameRow),
    .strobe(strobe), .ready(ready)
  );

  dramSeqPath #(.ROW_W(ROW_W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqData(reqData), .memDout(memDout),
    .sameRow(sameRow), .rdData(rdData), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memDin(memDin)
  );

endmodule

// File: rtl/dramSeqChk.sv
module dramSeqChk #(
  parameter int ROW_W    = 8,
  parameter int T_RASMIN = 15,
  parameter int T_RP     = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             ready,
  input logic [ROW_W-1:0] memAddr,
  input logic             memRasN,
  input logic             memCasN,
  input logic             memWeN
);

  logic [15:0] lowLen, highLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLen  <= '0;
      highLen <= '1;
    end else begin
      lowLen  <= memRasN ? '0 : lowLen + 1'b1;
      highLen <= !memRasN ? '0 : ((highLen == '1) ? highLen : highLen + 1'b1);
    end
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rstN)
    !memCasN |-> !memRasN); // R13
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |=> $stable(memAddr)); // R3
  AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && $past(!memCasN)) |-> $stable(memAddr)); // R6
  AST_WE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!memCasN && $past(!memCasN)) |-> $stable(memWeN)); // R8
  AST_READY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready); // R9
  AST_READY_AT_CAS_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memCasN) |-> ready); // R9
  AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRasN) |-> (lowLen >= 16'(T_RASMIN))); // R5
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |-> (highLen >= 16'(T_RP))); // R5

endmodule

bind dramSeq dramSeqChk #(.ROW_W(ROW_W), .T_RASMIN(T_RASMIN), .T_RP(T_RP)) u_chk (
  .clk(clk), .rstN(rstN), .ready(ready), .memAddr(memAddr),
  .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN)
);

// File: tb/dramSeq_tb.sv
module dramSeq_tb;

  localparam int T_INIT = 300, INIT_CYC = 8, T_RCD = 3, T_RAH = 2, T_CAS = 8;
  localparam int T_RASMIN = 15, T_RASMAX = 60, T_RP = 10, T_RC = 27, T_CP = 6, T_PC = 15;

  logic clk = 0, rstN = 0, req = 0, reqWrite = 0, reqData = 0, memDout = 0;
  logic [15:0] reqAddr = '0;
  wire ready, rdData, memRasN, memCasN, memWeN, memDin;
  wire [7:0] memAddr;

  dramSeq #(.T_INIT(T_INIT), .INIT_CYC(INIT_CYC), .T_RCD(T_RCD), .T_RAH(T_RAH),
    .T_CAS(T_CAS), .T_RASMIN(T_RASMIN), .T_RASMAX(T_RASMAX), .T_RP(T_RP),
    .T_RC(T_RC), .T_CP(T_CP), .T_PC(T_PC)) u_dut (
    .clk(clk), .rstN(rstN), .req(req), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqData(reqData), .ready(ready), .rdData(rdData), .memAddr(memAddr),
    .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN), .memDin(memDin),
    .memDout(memDout));

  always #4 clk = ~clk;

  int vectors = 0, miscompares = 0, cycN = 0, rasFalls = 0;
  int lastRasFall = -1000, lastRasRise = -1000, lastCasFall = -1000, lastCasRise = -1000;
  bit prevRas = 1, prevCas = 1, prevWe = 1, prevReady = 0, firstCas = 0, finished = 0;
  logic [7:0] rowLat = '0, colLat = '0;
  bit cells[int];
  bit refMem[int];
  typedef struct { bit isRead; bit exp; int addr; } exp_t;
  exp_t expQ[$];
  exp_t e;

  function automatic bit initBit(int a);
    return ^(a[15:0] ^ 16'h5A3C);
  endfunction

  function automatic bit cellVal(int k);
    return cells.exists(k) ? cells[k] : initBit(k);
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Memory model and per-cycle timing reference
  always @(negedge clk) begin
    if (!rstN) begin
      chk(memRasN && memCasN && memWeN && !ready, "R1 reset idle",
          {memRasN, memCasN, memWeN, ready}, 4'b1110);
    end else begin
      cycN++;
      if (prevRas && !memRasN) begin
        if (rasFalls == 0) chk(cycN >= T_INIT, "R1 power-up pause", cycN, T_INIT);
        chk(cycN - lastRasRise >= T_RP, "R5 precharge", cycN - lastRasRise, T_RP);
        chk(cycN - lastRasFall >= T_RC, "R5 RAS period", cycN - lastRasFall, T_RC);
        rasFalls++; lastRasFall = cycN; rowLat = memAddr; firstCas = 1;
      end
      if (!prevRas && memRasN) begin
        chk(cycN - lastRasFall >= T_RASMIN, "R5 RAS low width", cycN - lastRasFall, T_RASMIN);
        lastRasRise = cycN;
      end
      if (!memRasN) begin
        chk(cycN - lastRasFall + 1 <= T_RASMAX, "R12 RAS low limit", cycN - lastRasFall + 1, T_RASMAX);
        if (cycN == lastRasFall + 1) chk(memAddr == rowLat, "R3 row hold", memAddr, rowLat);
      end
      if (!memCasN) chk(!memRasN, "R13 CAS inside RAS", memRasN, 0);
      if (prevCas && !memCasN) begin
        chk(rasFalls > INIT_CYC, "R2 dummy cycles first", rasFalls, INIT_CYC + 1);
        if (firstCas) chk(cycN - lastRasFall >= T_RCD, "R4 RAS to CAS", cycN - lastRasFall, T_RCD);
        else begin
          chk(cycN - lastCasRise >= T_CP, "R10 CAS high", cycN - lastCasRise, T_CP);
          chk(cycN - lastCasFall >= T_PC, "R10 page cycle", cycN - lastCasFall, T_PC);
        end
        firstCas = 0; lastCasFall = cycN; colLat = memAddr;
        if (!memWeN) cells[{16'h0, rowLat, colLat}] = memDin; // R8 early write
      end else if (!memCasN) begin
        chk(memAddr == colLat, "R6 column hold", memAddr, colLat);
        chk(memWeN == prevWe, "R8 WE steady", memWeN, prevWe);
      end
      if (!prevCas && memCasN) begin
        chk(cycN - lastCasFall >= T_CAS, "R6 CAS width", cycN - lastCasFall, T_CAS);
        chk(ready, "R9 ready at CAS end", ready, 1);
        lastCasRise = cycN;
      end
      if (ready) begin
        chk(!prevReady, "R9 one-cycle ready", prevReady, 0);
        if (expQ.size() == 0) chk(0, "R9 unexpected ready", 1, 0);
        else begin
          e = expQ.pop_front();
          if (e.isRead) chk(rdData == e.exp, "R7 read data", rdData, e.exp);
        end
      end
      // data-out becomes valid only after full access time
      if (!memCasN) memDout <= (cycN - lastCasFall + 1 >= T_CAS) ?
                               cellVal({16'h0, rowLat, colLat}) : ~cellVal({16'h0, rowLat, colLat});
      else memDout <= 1'b0;
      prevRas = memRasN; prevCas = memCasN; prevWe = memWeN; prevReady = ready;
    end
  end

  task automatic access(bit w, logic [15:0] a, bit d);
    exp_t x;
    req = 1; reqWrite = w; reqAddr = a; reqData = d;
    x.isRead = !w; x.addr = a;
    x.exp = refMem.exists(a) ? refMem[a] : initBit(a);
    if (w) refMem[a] = d;
    expQ.push_back(x);
    do @(negedge clk); while (!ready);
  endtask

  task automatic idle(int n);
    req = 0; reqWrite = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    rstN = 1;
    // R2: request held through initialisation
    access(1, 16'h1234, 1);
    access(0, 16'h1234, 0);
    idle(80);
    // R10: same-row run shares one RAS phase
    r0 = rasFalls;
    access(1, 16'h5601, ~initBit(16'h5601));
    access(1, 16'h5602, ~initBit(16'h5602));
    access(0, 16'h5601, 0);
    chk(rasFalls - r0 == 1, "R10 one RAS for page run", rasFalls - r0, 1);
    idle(80);
    access(0, 16'h5602, 0);
    idle(80);
    // R11: alternating rows each reopen
    r0 = rasFalls;
    access(0, 16'h1234, 0);
    access(1, 16'hAB00, 1);
    access(0, 16'h1234, 0);
    chk(rasFalls - r0 == 3, "R11 new RAS per row change", rasFalls - r0, 3);
    idle(80);
    // R12: long same-row run split at RAS-low limit
    r0 = rasFalls;
    for (int i = 0; i < 6; i++) access(i < 3, {8'h77, 8'(i * 37)}, i[0]);
    chk(rasFalls - r0 >= 2 && rasFalls - r0 <= 6, "R12 burst split", rasFalls - r0, 2);
    idle(80);
    // R3: byte order - swapped-byte pair
    access(1, 16'h3412, 0);
    idle(80);
    access(0, 16'h1234, 0);
    access(0, 16'h3412, 0);
    access(0, 16'hC3E1, 0);
    idle(80);
    chk(expQ.size() == 0, "R9 one ready per request", expQ.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

endmodule